// File: doc/BRIEF.md
# Two-Wire ADC Result Reader

This block is a two-wire bus master that fetches one conversion result from a 12-bit converter. A one-cycle `start` pulse begins a read. The master generates a START condition and sends the 7-bit slave address followed by a read bit. It checks the slave's acknowledge and then clocks in two bytes. It acknowledges the first byte and leaves the second unacknowledged. It finishes with a STOP condition and reports the result with a completion pulse and two error flags.

The converter sends four constant ones ahead of its twelve data bits. The master removes this nibble and checks that it really is all ones. The remaining bits are joined most significant bit first into a 12-bit word. Both bus lines are open-drain. Each is modelled as an output enable that pulls the line low, plus an input that returns the resolved level. The SCL half-period is a count of system clocks, taken from `div` when a read starts.

Top module: `adc_rd_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `done`, `err_nack` and `err_frame` are 0 and `result` is 0. Whenever `busy` is 0, both output enables are 0 (both lines released).
- R2: A read begins with SDA pulled low while SCL is high (START). The next 8 SCL pulses carry `addr[6]` down to `addr[0]` and then a read bit of 1. SDA is sampled by the slave on each SCL rising edge.
- R3: On the 9th SCL pulse the master samples SDA. If SDA is high (no acknowledge), the master generates STOP after exactly 9 pulses, raises `err_nack`, clears `err_frame` and leaves `result` at its previous value.
- R4: If the address is acknowledged, the master releases SDA for pulses 10-17 and 19-26 and reads one data bit on each. It pulls SDA low on pulse 18 and releases it on pulse 27, and generates STOP after exactly 27 pulses.
- R5: After an acknowledged read, `result` is {first byte bits 3:0, second byte bits 7:0}. Bits arrive most significant first.
- R6: After an acknowledged read, `err_frame` is 1 exactly when the first byte's bits 7:4 are not 4'b1111. `result` is still updated.
- R7: SDA changes while SCL is high only twice in a read: the START fall and the final STOP rise, which is SDA released while SCL is high. SDA never changes in the cycle in which SCL changes.
- R8: Every SCL low and high phase of a read lasts max(`div`,2) system clocks. `div` is captured when the read starts.
- R9: `done` is a single-cycle pulse at the end of a read. `busy` is 1 from the cycle after an accepted `start` until `done`. A `start` that arrives while busy is ignored, along with the `div` and `addr` values present with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a read (accepted when idle) |
| div | input | DIVW | SCL half-period in system clocks (values below 2 act as 2) |
| addr | input | 7 | Slave address |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| err_nack | output | 1 | Address was not acknowledged |
| err_frame | output | 1 | Upper nibble of the first byte was not all ones |
| result | output | 12 | Assembled conversion result |

## Verification
The case in which two functions share a moment is a `start` pulse that lands in the middle of a transfer. It carries a new `div` and a new address, so acceptance of a new read would meet the ongoing bit sequencing. The bench raises it forty cycles into selected reads. It then judges the outcome at the bus: exactly one START must be seen, the address byte must be the original one, and every SCL phase must keep the original length. A second overlap is framing error and address error meeting at completion. Reads with a bad nibble and reads without acknowledge are mixed in the sweep to confirm that only the proper flag rises.

// File: rtl/adc_rd_master.sv
module adc_rd_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIVW-1:0] div,
  input  logic [6:0]      addr,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy,
  output logic            done,
  output logic            err_nack,
  output logic            err_frame,
  output logic [11:0]     result
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_LOW, S_HIGH, S_STOP1, S_STOP2, S_STOP3} st_t;
  localparam logic [4:0] ACK_SLOT  = 5'd8;
  localparam logic [4:0] MACK_SLOT = 5'd17;
  localparam logic [4:0] LAST_SLOT = 5'd26;
  localparam logic [DIVW-1:0] MIN_HP = DIVW'(2);

  st_t             st;
  logic [DIVW-1:0] hp, cnt;
  logic [4:0]      bitn;
  logic [6:0]      aq;
  logic [15:0]     sh;
  logic            nak, want_low;

  wire [DIVW-1:0] div_eff = (div < MIN_HP) ? MIN_HP : div;
  wire tick    = (cnt == '0);
  wire sample  = (st == S_HIGH) && (cnt == hp - 1'b1) && scl_i;
  wire data_bt = ((bitn > ACK_SLOT) && (bitn < MACK_SLOT)) ||
                 ((bitn > MACK_SLOT) && (bitn < LAST_SLOT));

  assign scl_oe = (st == S_LOW) || (st == S_STOP1);
  assign busy   = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START, S_STOP1, S_STOP2: want_low = 1'b1;
      S_LOW, S_HIGH:
        if (bitn < 5'd7) want_low = ~aq[3'd6 - bitn[2:0]];
        else             want_low = (bitn == MACK_SLOT);
      default: want_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  hp <= MIN_HP;  cnt <= '0;  bitn <= '0;  aq <= '0;
      sh <= '0;  nak <= 1'b0;  sda_oe <= 1'b0;  done <= 1'b0;
      err_nack <= 1'b0;  err_frame <= 1'b0;  result <= '0;
    end else begin
      done   <= 1'b0;
      sda_oe <= want_low;
      if (sample) begin
        if (bitn == ACK_SLOT) nak <= sda_i;
        if (data_bt) sh <= {sh[14:0], sda_i};
      end
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_START;  hp <= div_eff;  cnt <= div_eff - 1'b1;
          aq <= addr;  bitn <= '0;  nak <= 1'b0;
          err_nack <= 1'b0;  err_frame <= 1'b0;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= hp - 1'b1;
        case (st)
          S_START: st <= S_LOW;
          S_LOW:   st <= S_HIGH;
          S_HIGH:
            if ((bitn == ACK_SLOT && nak) || bitn == LAST_SLOT) st <= S_STOP1;
            else begin
              bitn <= bitn + 1'b1;
              st   <= S_LOW;
            end
          S_STOP1: st <= S_STOP2;
          S_STOP2: st <= S_STOP3;
          default: begin
            st       <= S_IDLE;
            done     <= 1'b1;
            err_nack <= nak;
            if (!nak) begin
              result    <= sh[11:0];
              err_frame <= (sh[15:12] != 4'hF);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_rd_master_chk.sv
module adc_rd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic err_nack,
  input logic err_frame
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_start_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> ($past(start, 2) && !$past(busy, 2)));

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_nack) |-> !err_frame);

  p_sda_quiet_on_scl_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind adc_rd_master adc_rd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .done(done), .err_nack(err_nack), .err_frame(err_frame)
);

// File: tb/sim_adc_rd_master.sv
module sim_adc_rd_master;
  localparam int DIVW = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DIVW-1:0] div = 8'd2;
  logic [6:0] addr = 7'd0;
  logic scl_oe, sda_oe, busy, done, err_nack, err_frame;
  logic [11:0] result;
  logic s_pull = 1'b0;
  wire scl_i = ~scl_oe;
  wire sda_i = ~(sda_oe | s_pull);

  always #10 clk = ~clk;

  adc_rd_master #(.DIVW(DIVW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .div(div), .addr(addr),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .err_nack(err_nack), .err_frame(err_frame),
    .result(result));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  logic [6:0] s_addr = 7'd0;
  logic s_ack_en = 1'b0, in_x = 1'b0, ack_ok = 1'b0, m18 = 1'b0, m27 = 1'b0;
  logic [7:0] s_b1 = 8'd0, s_b2 = 8'd0, rx = 8'd0;
  int k = 0, starts = 0, stops = 0, klast = 0;
  int lo_min, lo_max, hi_min, hi_max, run = 0;
  logic scl_prev = 1'b1;

  always @(negedge sda_i) if (scl_i === 1'b1 && rst_n) begin
    starts++; k = 0; s_pull = 1'b0; in_x = 1'b1; ack_ok = 1'b0;
  end
  always @(posedge sda_i) if (scl_i === 1'b1 && in_x) begin
    stops++; klast = k; in_x = 1'b0;
  end
  always @(posedge scl_i) if (in_x) begin
    k++;
    if (k <= 8) rx = {rx[6:0], sda_i};
    if (k == 18) m18 = sda_i;
    if (k == 27) m27 = sda_i;
  end
  always @(negedge scl_i) if (in_x) begin
    int s;
    s = k + 1;
    if (s == 9) ack_ok = s_ack_en && (rx[7:1] == s_addr);
    if (s == 9) s_pull = ack_ok;
    else if (s >= 10 && s <= 17) s_pull = ack_ok & ~s_b1[17-s];
    else if (s >= 19 && s <= 26) s_pull = ack_ok & ~s_b2[26-s];
    else s_pull = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (scl_i == scl_prev) run++;
    else begin
      if (in_x) begin
        if (!scl_prev) begin
          if (run < lo_min) lo_min = run;
          if (run > lo_max) lo_max = run;
        end else if (k >= 1) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
        end
      end
      run = 1; scl_prev = scl_i;
    end
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic txn(input int d, input logic [6:0] a, input logic [6:0] sa, input logic ack,
                     input logic [3:0] nib, input logic [11:0] v, input bit poke);
    int ehp, t;
    logic [11:0] prev;
    bit ok;
    ehp = (d < 2) ? 2 : d;
    prev = result;
    ok = ack && (sa == a);
    s_addr = sa; s_ack_en = ack; s_b1 = {nib, v[11:8]}; s_b2 = v[7:0];
    starts = 0; stops = 0; klast = 0;
    lo_min = 99999; lo_max = 0; hi_min = 99999; hi_max = 0;
    @(negedge clk); div = DIVW'(d); addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk); t++;
      if (poke && t == 40) begin start = 1'b1; div = DIVW'(d + 3); addr = ~a; end
      else if (poke && t == 41) start = 1'b0;
      if (!done && !busy) t = 20000;
    end
    chk(done == 1'b1, "R9 done reached", int'(done), 1);
    chk(rx == {a, 1'b1}, "R2 address byte", int'(rx), int'({a, 1'b1}));
    chk(starts == 1, "R2 single START", starts, 1);
    chk(stops == 1, "R7 single STOP", stops, 1);
    if (ok) begin
      chk(klast - 1 == 27, "R4 pulse count", klast - 1, 27);
      chk(m18 == 1'b0, "R4 master ack on pulse 18", int'(m18), 0);
      chk(m27 == 1'b1, "R4 master release on pulse 27", int'(m27), 1);
    end else
      chk(klast - 1 == 9, "R3 pulse count after nack", klast - 1, 9);
    chk(err_nack == !ok, "R3 err_nack", int'(err_nack), int'(!ok));
    chk(result == (ok ? v : prev), "R5 result", int'(result), int'(ok ? v : prev));
    chk(err_frame == (ok && nib != 4'hF), "R6 err_frame", int'(err_frame),
        int'(ok && nib != 4'hF));
    chk(lo_min == ehp && lo_max == ehp, "R8 low phase", lo_max * 1000 + lo_min, ehp * 1001);
    chk(hi_min == ehp && hi_max == ehp, "R8 high phase", hi_max * 1000 + hi_min, ehp * 1001);
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", int'({done, busy}), 0);
    chk(!scl_oe && !sda_oe, "R1 lines released when idle", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset outputs",
        int'({scl_oe, sda_oe, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!err_nack && !err_frame && result == 12'd0, "R1 reset flags",
        int'({err_nack, err_frame, result}), 0);
    foreach (u0.result[b]) ; // no-op keeps loop style uniform
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di == 0) ? 1 : (di == 3) ? 5 : di + 1;
      for (int i = 0; i < 16; i++) begin
        logic [6:0] a;
        logic [3:0] nib;
        a = 7'(7'h35 + i);
        nib = (i % 5 == 4) ? (4'(i) & 4'h7) : 4'hF;
        txn(d, a, (i == 13) ? (a ^ 7'h01) : a, (i % 7 != 6), nib,
            12'(i * 273 + d * 37), (i == 5));
      end
    end
    txn(2, 7'h00, 7'h00, 1'b1, 4'hF, 12'h000, 1'b0);
    txn(2, 7'h7F, 7'h7F, 1'b1, 4'hF, 12'hFFF, 1'b0);
    txn(3, 7'h2A, 7'h2A, 1'b1, 4'h0, 12'hAAA, 1'b0);
    txn(4, 7'h55, 7'h55, 1'b1, 4'hE, 12'h555, 1'b1);
    txn(2, 7'h11, 7'h11, 1'b0, 4'hF, 12'h123, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule